// File: doc/BRIEF.md
# Self-Configuring Multiplexed Bus Read Master

This block runs the host side of a 16-bit shared address/data lane. It reaches a memory through two latch-enable strobes and one active-low read strobe. A 32-bit byte address goes out in two halves. The upper half is sent while both latch enables are high. The lower half is sent while only the low latch enable is high. The master then releases the lane and pulses the read strobe once per 16-bit word. It captures each word on the rising edge of the read strobe.

Right after reset the block fetches the 32-bit configuration word that sits at byte offset 0. It does this with the slowest timing it supports. It then splits that word into four byte fields and uses them as its timing for every later access:

- latency before the first strobe
- recovery time between strobes
- strobe low time
- page size

A host then starts transfers with a base address and a word count. A typical first transfer is the boot code at byte offset 0x40. Words come back on a data output with a one-clock valid flag, and a one-clock done flag closes each transfer.

Top module: `mux_bus_master`

## Requirements
- R1: While reset is held, the read strobe is high, both latch enables are low, the lane is not driven, and done and rd_valid are low. After reset the master reads the two bus words at byte addresses 0 and 2 in one address phase without raising rd_valid. It then pulses done once. A start that arrives before that done is ignored.
- R2: The configuration read uses the default timing, which is 255 in every field. This gives a 256-clock latency, a 256-clock strobe low time and a 256-clock recovery.
- R3: The configuration word is formed with the word at byte 0 as bits 31:16 and the word at byte 2 as bits 15:0. Bits 31:24 are the latency, 23:16 the recovery, 15:8 the strobe width and 7:0 the page field. The new timing governs every access after the configuration done.
- R4: Each address phase drives ale_hi and ale_lo high with address bits 31:16 on the lane for ALE_CYC clocks. It then drives only ale_lo high with bits 15:0 for ALE_CYC clocks.
- R5: From the clock in which ale_lo falls to the first read strobe low, rd_n stays high for latency+1 clocks.
- R6: Each read strobe is low for exactly width+1 clocks.
- R7: Between two strobes of the same address phase, rd_n is high for exactly recovery+1 clocks.
- R8: The lane is not driven in the clock before rd_n falls, nor in any clock in which rd_n is low.
- R9: Each word is sampled at the rising edge of rd_n. It is presented on rd_data with rd_valid high for one clock, in the clock in which rd_n has returned high. Word i of a transfer comes from byte address base+2*i.
- R10: A page holds 2^min(page field, 15) words, counting word index = byte address / 2. A word whose index is a multiple of the page size starts a fresh address phase.
- R11: No more than 256 words are read in one address phase. The 257th word of an unbroken run starts a fresh address phase.
- R12: done is high for one clock after the last word's recovery. A count of zero produces done with no bus activity.
- R13: A start asserted while a transfer is in progress is ignored and does not change its words or its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, taken only when idle |
| base_addr | input | 32 | Byte address of the first word |
| word_cnt | input | 16 | Number of 16-bit words to read |
| rd_data | output | 16 | Returned word |
| rd_valid | output | 1 | rd_data holds a new word this clock |
| done | output | 1 | One-clock end-of-transfer pulse |
| ale_hi | output | 1 | High latch enable |
| ale_lo | output | 1 | Low latch enable |
| rd_n | output | 1 | Active-low read strobe |
| ad_out | output | 16 | Lane value while driven |
| ad_oe | output | 1 | Lane drive enable |
| ad_in | input | 16 | Lane value returned by the memory |

## Verification
The bench boots the master from five configuration words. These include the typical header value and the very slow one with a 256-clock strobe. It measures every latency, strobe low time and recovery gap against the fields it put in the header. A master that kept its default timing, or that decoded the fields in the wrong byte order, shows the wrong widths right after boot.

Page splitting is swept with a one-word page, a four-word page starting mid-page and a 300-word run on a huge page. A wrong boundary mask, or a missing 256-word cap, gives the wrong count of address phases or wrong data after the break. Zero-length requests are tested, as are starts during boot or mid-transfer. These expose a master that hangs, skips done, or lets a second request corrupt the running one.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
   localparam int FIELD_W = 8;

   typedef struct packed {
      logic [FIELD_W-1:0] lat;
      logic [FIELD_W-1:0] rel;
      logic [FIELD_W-1:0] pw;
      logic [FIELD_W-1:0] page;
   } mbm_timing_t;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_AHI,
      ST_ALO,
      ST_LAT,
      ST_PULSE,
      ST_REL,
      ST_DONE
   } mbm_state_e;
endpackage

// File: rtl/mbm_timer.sv
module mbm_timer #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

   // R6: once counting, the value only decreases until reloaded
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/mbm_cfg.sv
module mbm_cfg #(
   parameter int AD_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_en,
   input  logic                 cap_hi,
   input  logic [AD_W-1:0]      word,
   input  logic                 commit,
   output mbm_pkg::mbm_timing_t timing
);
   localparam int CW = 2 * AD_W;

   logic [CW-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage <= '0;
      else if (cap_en) begin
         if (cap_hi)
            stage[CW-1:AD_W] <= word;
         else
            stage[AD_W-1:0] <= word;
      end
   end

   // R2: slowest timing in every field until the header is committed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         timing <= '1;
      else if (commit)
         timing <= mbm_pkg::mbm_timing_t'(stage);
   end

   // R3: timing only changes on a commit
   a_r3_timing_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit) |-> $stable(timing));
endmodule

// File: rtl/mbm_addr_track.sv
module mbm_addr_track #(
   parameter int ADDR_W        = 32,
   parameter int CNT_W         = 16,
   parameter int MAX_BURST     = 256,
   parameter int PAGE_LOG2_MAX = 15,
   parameter int FIELD_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic [CNT_W-1:0]   load_cnt,
   input  logic               advance,
   input  logic               restart,
   input  logic [FIELD_W-1:0] page_field,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic               last,
   output logic               brk
);
   localparam int BC_W = $clog2(MAX_BURST) + 1;

   logic [CNT_W-1:0]         rem;
   logic [BC_W-1:0]          bcnt;
   logic [FIELD_W-1:0]       k_lim;
   logic [PAGE_LOG2_MAX-1:0] mask;
   logic [PAGE_LOG2_MAX-1:0] widx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         rem      <= '0;
         bcnt     <= '0;
      end else if (load) begin
         cur_addr <= load_addr;
         rem      <= load_cnt;
         bcnt     <= '0;
      end else if (advance) begin
         cur_addr <= cur_addr + ADDR_W'(2);
         rem      <= rem - CNT_W'(1);
         bcnt     <= bcnt + BC_W'(1);
      end else if (restart) begin
         bcnt     <= '0;
      end
   end

   assign k_lim = (page_field > FIELD_W'(PAGE_LOG2_MAX)) ? FIELD_W'(PAGE_LOG2_MAX) : page_field;

   for (genvar i = 0; i < PAGE_LOG2_MAX; i++) begin : g_mask
      assign mask[i] = (k_lim > FIELD_W'(i));
   end

   assign widx = cur_addr[PAGE_LOG2_MAX:1];
   assign last = (rem == '0);
   assign brk  = ((widx & mask) == '0) || (bcnt == BC_W'(MAX_BURST));

   // R11: an address phase never carries more than MAX_BURST words
   a_r11_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= BC_W'(MAX_BURST));
   // R12: no word is fetched past the requested count
   a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (rem != '0));
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
   parameter int AD_W          = 16,
   parameter int CNT_W         = 16,
   parameter int MAX_BURST     = 256,
   parameter int PAGE_LOG2_MAX = 15,
   parameter int ALE_CYC       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2*AD_W-1:0]   base_addr,
   input  logic [CNT_W-1:0]    word_cnt,
   output logic [AD_W-1:0]     rd_data,
   output logic                rd_valid,
   output logic                done,
   output logic                ale_hi,
   output logic                ale_lo,
   output logic                rd_n,
   output logic [AD_W-1:0]     ad_out,
   output logic                ad_oe,
   input  logic [AD_W-1:0]     ad_in
);
   import mbm_pkg::*;

   localparam int ADDR_W     = 2 * AD_W;
   localparam int TW         = FIELD_W + 1;
   localparam int BOOT_WORDS = 2;

   initial begin
      assert (ADDR_W == 4 * FIELD_W) else $error("config word must fill two lane words");
      assert (MAX_BURST == (1 << $clog2(MAX_BURST))) else $error("MAX_BURST must be a power of two");
      assert (PAGE_LOG2_MAX < ADDR_W) else $error("page span exceeds address");
      assert (ALE_CYC >= 1 && ALE_CYC <= (1 << FIELD_W)) else $error("ALE_CYC out of range");
      assert (CNT_W >= 2) else $error("count too narrow");
   end

   mbm_state_e        state, nxt;
   logic              booting;
   logic              t_load, t_exp;
   logic [TW-1:0]     t_val;
   logic              trk_load, adv, rst_b, commit;
   logic [ADDR_W-1:0] trk_addr, cur_addr;
   logic [CNT_W-1:0]  trk_cnt;
   logic              last, brk;
   logic              sample;
   mbm_timing_t       timing;

   mbm_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
   );

   mbm_cfg #(.AD_W(AD_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cap_en(sample && booting), .cap_hi(!cur_addr[1]),
      .word(ad_in), .commit(commit), .timing(timing)
   );

   mbm_addr_track #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST),
      .PAGE_LOG2_MAX(PAGE_LOG2_MAX), .FIELD_W(FIELD_W)
   ) u_trk (
      .clk(clk), .rst_n(rst_n),
      .load(trk_load), .load_addr(trk_addr), .load_cnt(trk_cnt),
      .advance(adv), .restart(rst_b), .page_field(timing.page),
      .cur_addr(cur_addr), .last(last), .brk(brk)
   );

   assign sample = (state == ST_PULSE) && t_exp;

   always_comb begin
      nxt      = state;
      t_load   = 1'b0;
      t_val    = '0;
      trk_load = 1'b0;
      trk_addr = base_addr;
      trk_cnt  = word_cnt;
      adv      = 1'b0;
      rst_b    = 1'b0;
      commit   = 1'b0;
      case (state)
         ST_BOOT: begin
            trk_load = 1'b1;
            trk_addr = '0;
            trk_cnt  = CNT_W'(BOOT_WORDS);
            t_load   = 1'b1;
            t_val    = TW'(ALE_CYC - 1);
            nxt      = ST_AHI;
         end
         ST_IDLE: begin
            if (start) begin
               if (word_cnt == '0)
                  nxt = ST_DONE;
               else begin
                  trk_load = 1'b1;
                  t_load   = 1'b1;
                  t_val    = TW'(ALE_CYC - 1);
                  nxt      = ST_AHI;
               end
            end
         end
         ST_AHI: if (t_exp) begin
            t_load = 1'b1;
            t_val  = TW'(ALE_CYC - 1);
            nxt    = ST_ALO;
         end
         ST_ALO: if (t_exp) begin
            t_load = 1'b1;
            t_val  = TW'(timing.lat);
            nxt    = ST_LAT;
         end
         ST_LAT: if (t_exp) begin
            t_load = 1'b1;
            t_val  = TW'(timing.pw);
            nxt    = ST_PULSE;
         end
         ST_PULSE: if (t_exp) begin
            adv    = 1'b1;
            t_load = 1'b1;
            t_val  = TW'(timing.rel);
            nxt    = ST_REL;
         end
         ST_REL: if (t_exp) begin
            if (last)
               nxt = ST_DONE;
            else if (brk) begin
               rst_b  = 1'b1;
               t_load = 1'b1;
               t_val  = TW'(ALE_CYC - 1);
               nxt    = ST_AHI;
            end else begin
               t_load = 1'b1;
               t_val  = TW'(timing.pw);
               nxt    = ST_PULSE;
            end
         end
         ST_DONE: begin
            commit = booting;
            nxt    = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BOOT;
         booting <= 1'b1;
      end else begin
         state <= nxt;
         if (state == ST_DONE)
            booting <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= sample && !booting;
         if (sample && !booting)
            rd_data <= ad_in;
      end
   end

   assign ale_hi = (state == ST_AHI);
   assign ale_lo = (state == ST_AHI) || (state == ST_ALO);
   assign rd_n   = (state != ST_PULSE);
   assign ad_out = (state == ST_AHI) ? cur_addr[ADDR_W-1:AD_W] : cur_addr[AD_W-1:0];
   assign ad_oe  = (state == ST_AHI) || (state == ST_ALO) || ((state == ST_LAT) && !t_exp);
   assign done   = (state == ST_DONE);

   // R8: never drive the lane while the memory may be driving it
   a_r8_lane_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);
   // R8: lane released one clock ahead of the strobe
   a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> !$past(ad_oe));
   // R4: upper half only with both latch enables high
   a_r4_upper_both: assert property (@(posedge clk) disable iff (!rst_n)
      ale_hi |-> ale_lo);
   // R4: lower half phase follows the upper half
   a_r4_lower_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale_hi) |-> ale_lo);
   // R9: data presented in the clock the strobe returns high
   a_r9_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(rd_n));
   // R12: done only while the bus is quiet
   a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_n && !ale_lo));
endmodule

// File: tb/sim_mux_bus_master.sv
`timescale 1ns/1ps
module sim_mux_bus_master;
   localparam int ALE = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] word_cnt = '0;
   logic [15:0] rd_data;
   logic        rd_valid, done, ale_hi, ale_lo, rd_n, ad_oe;
   logic [15:0] ad_out, ad_in;

   always #2.5 clk = ~clk;

   mux_bus_master #(.ALE_CYC(ALE)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .word_cnt(word_cnt), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .ale_hi(ale_hi), .ale_lo(ale_lo), .rd_n(rd_n), .ad_out(ad_out),
      .ad_oe(ad_oe), .ad_in(ad_in)
   );

   logic [31:0] hdr = 32'h0;
   int t_lat = 255, t_rel = 255, t_pw = 255;
   int req_id = 0;
   logic [31:0] req_base = '0;
   bit b_boot = 1'b1;
   int checks = 0, errs = 0;

   function automatic logic [15:0] memw(input logic [31:0] a);
      if (a == 32'd0) return hdr[31:16];
      if (a == 32'd2) return hdr[15:0];
      return a[16:1] ^ a[31:16] ^ 16'h5A3C;
   endfunction

   // memory model on the lane
   logic [31:0] sa = '0;
   logic        sp_rdn = 1'b1;
   always @(posedge clk) begin
      if (ale_hi) sa[31:16] <= ad_out;
      else if (ale_lo) sa[15:0] <= ad_out;
      if (rd_n && !sp_rdn) sa <= sa + 32'd2;
      sp_rdn <= rd_n;
   end
   assign ad_in = rd_n ? 16'hDEAD : memw(sa);

   // monitor
   int m_checks = 0, m_errs = 0;
   int m_strobes = 0, m_valids = 0, m_phases = 0, m_dones = 0, m_last_low = 0;
   int seen_id = -1;
   int hi_cnt, lo_cnt, lat_cnt, low_cnt, high_cnt;
   bit ph_bad, in_lat, oe_bad, prev_rdn, prev_oe, prev_alo;
   logic [31:0] expa;

   task automatic mchk(input bit ok, input string tag, input int act, input int exp);
      m_checks++;
      if (!ok) begin
         m_errs++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_rdn = 1; prev_oe = 0; prev_alo = 0; hi_cnt = 0; lo_cnt = 0;
         ph_bad = 0; in_lat = 0; lat_cnt = 0; low_cnt = 0; high_cnt = 0; oe_bad = 0;
      end else begin
         if (req_id != seen_id) begin
            seen_id = req_id; m_strobes = 0; m_valids = 0; m_phases = 0; m_dones = 0;
         end
         expa = req_base + 32'(2 * m_strobes);
         if (ale_hi) begin
            hi_cnt++;
            if (!ale_lo || ad_out != expa[31:16]) ph_bad = 1;
         end else if (ale_lo) begin
            lo_cnt++;
            if (ad_out != expa[15:0]) ph_bad = 1;
         end
         if (prev_alo && !ale_lo) begin
            mchk(hi_cnt == ALE && lo_cnt == ALE && !ph_bad, "R4 phase lengths/address", hi_cnt * 100 + lo_cnt, ALE * 101);
            m_phases++; hi_cnt = 0; lo_cnt = 0; ph_bad = 0; in_lat = 1; lat_cnt = 0;
         end
         if (in_lat && rd_n) lat_cnt++;
         if (!rd_n && prev_rdn) begin
            if (in_lat) mchk(lat_cnt == t_lat + 1, b_boot ? "R2 latency" : "R5 latency", lat_cnt, t_lat + 1);
            else        mchk(high_cnt == t_rel + 1, b_boot ? "R2 recovery" : "R7 recovery", high_cnt, t_rel + 1);
            in_lat = 0;
            mchk(!prev_oe, "R8 lane driven before strobe", prev_oe, 0);
            low_cnt = 0; oe_bad = 0;
         end
         if (!rd_n) begin
            low_cnt++;
            if (ad_oe) oe_bad = 1;
         end
         if (rd_n && !prev_rdn) begin
            mchk(low_cnt == t_pw + 1, b_boot ? "R2 strobe width" : "R6 strobe width", low_cnt, t_pw + 1);
            mchk(!oe_bad, "R8 lane driven during strobe", oe_bad, 0);
            m_last_low = low_cnt; m_strobes++; high_cnt = 0;
         end
         if (rd_n) high_cnt++;
         if (rd_valid) begin
            m_valids++;
            mchk(!b_boot, "R1 rd_valid during boot", 1, 0);
            mchk(rd_data == memw(req_base + 32'(2 * (m_strobes - 1))), "R9 data",
                 rd_data, memw(req_base + 32'(2 * (m_strobes - 1))));
         end
         if (done) m_dones++;
         prev_rdn = rd_n; prev_oe = ad_oe; prev_alo = ale_lo;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_phases(input logic [31:0] base, input int cnt, input int field);
      int p, b, k;
      logic [31:0] w;
      p = 0; b = 0;
      k = (field > 15) ? 15 : field;
      for (int i = 0; i < cnt; i++) begin
         w = (base >> 1) + 32'(i);
         if (i == 0 || (w & ((32'd1 << k) - 32'd1)) == 0 || b == 256) begin
            p++; b = 0;
         end
         b++;
      end
      return p;
   endfunction

   task automatic wait_done(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(posedge clk); #1;
         if (m_dones != 0) break;
      end
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic do_boot(input logic [31:0] h);
      @(posedge clk); #1;
      rst_n = 0; hdr = h; t_lat = 255; t_rel = 255; t_pw = 255;
      b_boot = 1; req_base = '0; req_id++; start = 0;
      repeat (4) @(posedge clk);
      #1;
      chk(rd_n && !ale_hi && !ale_lo && !ad_oe && !done && !rd_valid, "R1 reset state",
          {rd_n, ale_hi, ale_lo, ad_oe, done, rd_valid}, 6'b100000);
      rst_n = 1;
      @(posedge clk); #1;
      start = 1; base_addr = 32'h300; word_cnt = 16'd5;
      @(posedge clk); #1;
      start = 0;
      wait_done(3000);
      chk(m_dones == 1, "R1 boot done", m_dones, 1);
      chk(m_strobes == 2 && m_phases == 1 && m_valids == 0, "R1 boot words",
          m_strobes * 100 + m_phases * 10 + m_valids, 210);
      b_boot = 0;
      t_lat = int'(h[31:24]); t_rel = int'(h[23:16]); t_pw = int'(h[15:8]);
   endtask

   task automatic run_req(input logic [31:0] base, input int cnt, input string ptag, input int inject);
      int ep;
      ep = exp_phases(base, cnt, int'(hdr[7:0]));
      req_id++; req_base = base;
      base_addr = base; word_cnt = 16'(cnt); start = 1;
      @(posedge clk); #1;
      start = 0;
      if (inject > 0) begin
         repeat (inject) @(posedge clk);
         #1;
         base_addr = 32'h7000; word_cnt = 16'd1; start = 1;
         @(posedge clk); #1;
         start = 0;
      end
      wait_done(60000);
      chk(m_dones == 1, inject > 0 ? "R13 single done" : "R12 done", m_dones, 1);
      chk(m_valids == cnt, inject > 0 ? "R13 word count" : "R9 word count", m_valids, cnt);
      chk(m_phases == ep, ptag, m_phases, ep);
      if (cnt > 0) chk(m_last_low == t_pw + 1, "R3 header width applied", m_last_low, t_pw + 1);
   endtask

   initial begin
      do_boot(32'h80371240);
      run_req(32'h40, 8, "R10 phases typical", 0);

      do_boot(32'h00000040);
      run_req(32'h40, 300, "R11 phases at 256 cap", 0);
      run_req(32'h80, 0, "R12 zero count no phases", 0);

      do_boot(32'h02030102);
      run_req(32'h46, 9, "R10 phases page of 4", 0);
      run_req(32'h200, 6, "R13 phases", 20);

      do_boot(32'h01050000);
      run_req(32'h10, 3, "R10 phases page of 1", 0);

      do_boot(32'h8037FF40);
      run_req(32'h40, 2, "R10 phases slow", 0);

      $display("CHECKS %0d ERRORS %0d", checks + m_checks, errs + m_errs);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errs + m_errs + 1);
      $finish;
   end
endmodule